// File: doc/BRIEF.md
# Packed Pixel Unpacker with Palette

This block sits between a line-fetch engine and a display timing generator. It accepts 32-bit words of frame data over a valid/ready input. For each pixel request from the timing side, it produces one color. A 3-bit depth code sets how densely pixels are packed in each word: 1, 2, 4 or 8 bits per pixel for indexed images, or 12 or 16 bits per pixel for direct color.

Indexed pixels are used as an address into an on-chip palette RAM, which is loaded through a separate write port. Direct-color pixels bypass the palette. A register stage delays them so that every depth returns its color exactly one cycle after the request.

An inversion control flips every bit of the pixel value before it is used. A request that arrives while no word is held is answered with black and a one-cycle underrun flag.

Top module: `pixel_unpacker`

## Requirements
- R1: Depth code 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel, giving 32, 16, 8 and 4 pixels per word. Pixel 0 of a word is taken from its most significant bits, and later pixels follow toward bit 0.
- R2: Depth code 4 selects 12 bits per pixel and depth code 5 selects 16 bits per pixel. In both modes a word carries two 16-bit slots, upper slot first. A 12-bit pixel is the low 12 bits of its slot, and the top 4 bits of the slot are ignored. Codes 6 and 7 behave like code 5.
- R3: For depth codes 0 to 3, the output color is the palette entry addressed by the pixel value. For codes 4 to 7, the output color is the pixel value zero-extended.
- R4: A palette write stores `pal_wdata` at `pal_addr` on a clock edge where `pal_we` is high. Later lookups of that index return the stored value.
- R5: When `invert` is high, the pixel value is XORed with an all-ones mask of the pixel width. This happens before the palette lookup or the direct output.
- R6: `pix_valid` is high exactly one cycle after each cycle in which `pix_req` is high, in every depth mode, and low otherwise.
- R7: A request made while no word is held yields `pix_valid` high, `underrun` high and a color of 0 in the following cycle. Such a request consumes nothing.
- R8: `word_ready` is high when no word is held, or when the current request consumes the last pixel of the held word. A word accepted in that cycle supplies the next request, so back-to-back words cause no underrun.
- R9: After reset, `pix_valid` and `underrun` are low and `word_ready` is high.
- R10: `pix_color` is 0 whenever `pix_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| depth | input | 3 | Packing density code |
| invert | input | 1 | Invert pixel value bits |
| word_valid | input | 1 | Frame word offered |
| word_data | input | 32 | Frame word |
| word_ready | output | 1 | Frame word accepted when high with word_valid |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | PAL_AW | Palette write index |
| pal_wdata | input | COLOR_W | Palette write color |
| pix_req | input | 1 | Pixel request from timing generator |
| pix_valid | output | 1 | Color for the previous cycle's request |
| pix_color | output | COLOR_W | Output color |
| underrun | output | 1 | Previous request found no word held |

## Verification
The bench builds the block with its default parameters: an 8-bit palette index and 24-bit colors. With these values, every index reachable at 8 bits per pixel has its own palette entry, and both direct depths fit in the color unchanged.

All eight depth codes are swept with inversion off and on, using several words per setting and an irregular request pattern. This exercises every pixel slot position, the back-to-back word handover and the initial underrun. A final pass rewrites palette entries and reads them back through the 8-bit mode.

// File: rtl/pixel_unpacker.sv
module pixel_unpacker #(
  parameter int PAL_AW  = 8,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         depth,
  input  logic               invert,
  input  logic               word_valid,
  input  logic [31:0]        word_data,
  output logic               word_ready,
  input  logic               pal_we,
  input  logic [PAL_AW-1:0]  pal_addr,
  input  logic [COLOR_W-1:0] pal_wdata,
  input  logic               pix_req,
  output logic               pix_valid,
  output logic [COLOR_W-1:0] pix_color,
  output logic               underrun
);
  localparam int PAL_N = 1 << PAL_AW;

  logic [31:0] wbuf;
  logic        have;
  logic [4:0]  idx;

  logic [2:0]  lg;
  logic [4:0]  last_idx, sh;
  logic        last, indexed, take, consume;
  logic [15:0] mask, pix;
  logic [31:0] shifted;

  assign indexed  = (depth < 3'd4);
  assign lg       = indexed ? depth : 3'd4;
  assign last_idx = 5'd31 >> lg;
  assign last     = (idx == last_idx);
  assign sh       = (last_idx - idx) << lg;
  assign shifted  = wbuf >> sh;

  always_comb begin
    case (depth)
      3'd0:    mask = 16'h0001;
      3'd1:    mask = 16'h0003;
      3'd2:    mask = 16'h000f;
      3'd3:    mask = 16'h00ff;
      3'd4:    mask = 16'h0fff;
      default: mask = 16'hffff;
    endcase
  end

  assign pix        = (shifted[15:0] & mask) ^ (invert ? mask : 16'h0000);
  assign word_ready = !have || (pix_req && last);
  assign take       = word_valid && word_ready;
  assign consume    = pix_req && have;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf <= '0;
      have <= 1'b0;
      idx  <= '0;
    end else if (take) begin
      wbuf <= word_data;
      have <= 1'b1;
      idx  <= '0;
    end else if (consume) begin
      if (last) have <= 1'b0;
      else      idx  <= idx + 5'd1;
    end
  end

  logic [COLOR_W-1:0] pal [PAL_N];
  logic [COLOR_W-1:0] pal_q;

  always_ff @(posedge clk) begin
    if (pal_we) pal[pal_addr] <= pal_wdata;
    pal_q <= pal[PAL_AW'(pix)];
  end

  logic        vld_q, und_q, ind_q;
  logic [15:0] dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      und_q <= 1'b0;
      ind_q <= 1'b0;
      dir_q <= '0;
    end else begin
      vld_q <= pix_req;
      und_q <= pix_req && !have;
      ind_q <= indexed;
      dir_q <= pix;
    end
  end

  assign pix_valid = vld_q;
  assign underrun  = und_q;
  assign pix_color = (!vld_q || und_q) ? '0 : (ind_q ? pal_q : COLOR_W'(dir_q));
endmodule

// File: rtl/pixel_unpacker_chk.sv
module pixel_unpacker_chk #(
  parameter int COLOR_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_req,
  input logic               word_valid,
  input logic               word_ready,
  input logic               pix_valid,
  input logic               underrun,
  input logic [COLOR_W-1:0] pix_color
);
  a_r6_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |=> pix_valid);

  a_r6_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req |=> (!pix_valid && !underrun));

  a_r7_held_word_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && !word_ready) |=> !underrun);

  a_r8_handover_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) ##1 pix_req |=> !underrun);

  a_r10_idle_black: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (pix_color == '0));
endmodule

bind pixel_unpacker pixel_unpacker_chk #(.COLOR_W(COLOR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_req(pix_req), .word_valid(word_valid),
  .word_ready(word_ready), .pix_valid(pix_valid), .underrun(underrun),
  .pix_color(pix_color)
);

// File: tb/pixel_unpacker_bench.sv
`timescale 1ns/1ps
module pixel_unpacker_bench;
  localparam int PAL_AW  = 8;
  localparam int COLOR_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] depth = '0;
  logic invert = 1'b0;
  logic word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic word_ready;
  logic pal_we = 1'b0;
  logic [PAL_AW-1:0] pal_addr = '0;
  logic [COLOR_W-1:0] pal_wdata = '0;
  logic pix_req = 1'b0;
  logic pix_valid;
  logic [COLOR_W-1:0] pix_color;
  logic underrun;

  pixel_unpacker #(.PAL_AW(PAL_AW), .COLOR_W(COLOR_W)) u_pixel_unpacker (
    .clk(clk), .rst_n(rst_n), .depth(depth), .invert(invert),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
    .pix_req(pix_req), .pix_valid(pix_valid), .pix_color(pix_color),
    .underrun(underrun)
  );

  always #4 clk = ~clk;

  int vecs = 0;
  int fails = 0;
  logic [COLOR_W-1:0] pal_model [256];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int bits_of(input int d);
    if (d < 4) return 1 << d;
    if (d == 4) return 12;
    return 16;
  endfunction

  function automatic int slot_of(input int d);
    return (d < 4) ? (1 << d) : 16;
  endfunction

  function automatic logic [COLOR_W-1:0] color_of(input logic [31:0] w, input int i,
                                                  input int d, input bit inv);
    int s = slot_of(d);
    logic [31:0] m = (32'd1 << bits_of(d)) - 1;
    logic [31:0] p = (w >> (32 - (i + 1) * s)) & m;
    if (inv) p = p ^ m;
    if (d < 4) return pal_model[p[7:0]];
    return COLOR_W'(p);
  endfunction

  function automatic logic [31:0] wgen(input int k, input int d);
    return (32'h9E3779B9 * (k + 1)) ^ (32'h01010101 * d) ^ (32'h00F0_0F00 * k);
  endfunction

  task automatic pal_write(input int a, input logic [COLOR_W-1:0] v);
    @(negedge clk);
    pal_we = 1'b1; pal_addr = PAL_AW'(a); pal_wdata = v;
    pal_model[a] = v;
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  task automatic run_cfg(input int d, input bit inv, input int nw);
    bit m_have = 0;
    logic [31:0] m_word = '0;
    int m_idx = 0;
    int k = 0;
    int post = 0;
    int lastp = 32 / slot_of(d) - 1;
    string tag = (d < 4) ? (inv ? "R1 R3 R5" : "R1 R3") : (inv ? "R2 R3 R5" : "R2 R3");
    depth = 3'(d); invert = inv;
    for (int c = 0; c < 2000 && post < 3; c++) begin
      bit req = (c % 7) != 4;
      bit hs, e_u, exp_rdy;
      logic [COLOR_W-1:0] e_c;
      word_valid = (k < nw);
      word_data  = wgen(k, d);
      pix_req    = req;
      #1;
      exp_rdy = !m_have || (req && m_idx == lastp);
      chk("R8 word_ready", 32'(word_ready), 32'(exp_rdy));
      hs  = word_valid && word_ready;
      e_u = req && !m_have;
      e_c = (req && m_have) ? color_of(m_word, m_idx, d, inv) : '0;
      if (req && m_have) begin
        if (m_idx == lastp) m_have = 0;
        else m_idx++;
      end
      if (hs) begin
        m_word = word_data; m_have = 1; m_idx = 0; k++;
      end
      if (k == nw && !m_have) post++;
      @(posedge clk);
      @(negedge clk);
      chk("R6 pix_valid", 32'(pix_valid), 32'(req));
      chk("R7 underrun", 32'(underrun), 32'(e_u));
      if (!req) chk("R10 idle color", 32'(pix_color), 32'(0));
      else if (e_u) chk("R7 black on underrun", 32'(pix_color), 32'(0));
      else chk(tag, 32'(pix_color), 32'(e_c));
    end
    word_valid = 1'b0;
    pix_req = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9 pix_valid", 32'(pix_valid), 32'(0));
    chk("R9 underrun", 32'(underrun), 32'(0));
    chk("R9 word_ready", 32'(word_ready), 32'(1));
    // R4: fill the palette
    for (int a = 0; a < 256; a++)
      pal_write(a, COLOR_W'((a * 24'h010307) ^ 24'h5A3C00));
    for (int d = 0; d < 8; d++)
      for (int inv = 0; inv < 2; inv++)
        run_cfg(d, inv[0], 3);
    // R4: rewrite entries, then read them back at 8 bits per pixel
    for (int a = 0; a < 256; a += 17)
      pal_write(a, COLOR_W'(24'hC0FFEE ^ (a * 24'h000101)));
    run_cfg(3, 1'b0, 4);
    run_cfg(3, 1'b1, 4);
    finish_run();
  end
endmodule